// File: doc/BRIEF.md
# AC-Link Controller Frame Engine

This block is the controller end of a five-wire serial audio codec link. The codec supplies the bit clock. The block runs entirely on that clock. It drives the active-low codec reset, the frame SYNC and the outgoing serial line. It also samples the incoming serial line. Each frame is 256 bit clocks long. It carries thirteen time-multiplexed slots in each direction: a 16-bit tag slot (slot 0) followed by twelve 20-bit slots (slots 1 to 12). All fields are sent MSB first. At a 12.288 MHz bit clock the frame rate is 48 kHz.

On the parallel side, the host presents a tag word, a command address (slot 1), command data (slot 2) and ten PCM payloads (slots 3 to 12). It receives the same layout from the codec: tag, status address, status data and ten PCM payloads. A one-cycle frame strobe marks the frame boundary. At that boundary the received slots are published and the next outgoing slots are taken.

A three-state machine sequences the link:
- `LNK_RESET` holds the codec in reset.
- `LNK_GUARD` releases the reset but keeps SYNC and data low.
- `LNK_RUN` streams frames.

Transitions:
- `LNK_RESET -> LNK_GUARD` occurs when the reset timer expires.
- `LNK_GUARD -> LNK_RUN` occurs when the guard timer expires.
- Any state moves to `LNK_RESET` on `link_reset` or on `rst_n`.

The outgoing lines must be low whenever the codec reset is low, including at its rising edge. A high level there would put the codec into a test mode.

Top module: `aclink_frame_engine`

## Requirements
- R1: While `rst_n` is low, `ac_rst_n`, `ac_sync`, `ac_sdata_out` and `frame_strobe` are all 0. After `rst_n` is released, `ac_rst_n` stays low for exactly RST_CYCLES (default 16) bit clocks.
- R2: `ac_sync` and `ac_sdata_out` are 0 in every bit clock in which `ac_rst_n` is low. They are also 0 in the cycle where `ac_rst_n` rises and for GUARD_CYCLES (default 4) bit clocks counted from that cycle.
- R3: When `link_reset` is high at a rising bit-clock edge, that edge drives `ac_rst_n`, `ac_sync` and `ac_sdata_out` to 0. The R1/R2 sequence then restarts, with `ac_rst_n` low for RST_CYCLES bit clocks.
- R4: Each frame lasts 256 bit clocks, numbered 0 to 255. `ac_sync` is high in bit 255 of the previous frame and in bits 0 to 14 of the frame, which is 16 consecutive clocks. It is low in bits 15 to 254.
- R5: The first frame after the guard period begins with a single lead-in clock in which `ac_sync` is high and `ac_sdata_out` is 0. The tag MSB appears on `ac_sdata_out` in the next clock, which is bit 0.
- R6: Outgoing frame layout, MSB first, in bit order 0 to 255:
  - `tx_tag[15:0]` (slot 0);
  - `tx_cmd_addr[19:0]` (slot 1);
  - `tx_cmd_data[19:0]` (slot 2);
  - `tx_pcm[199:0]`, where slot 3 is `tx_pcm[199:180]` and slot 12 is `tx_pcm[19:0]`.
  
  Data changes on the rising edge of `bit_clk`.
- R7: The transmit inputs are sampled at the rising edge that ends bit 255 of a frame, or that ends the lead-in clock. They are then sent in the frame that starts at that edge.
- R8: `ac_sdata_in` is sampled on the falling edge of `bit_clk`. The bit received in clock k is frame bit k. Received frames appear on `rx_tag`, `rx_stat_addr`, `rx_stat_data` and `rx_pcm` in the same layout as R6.
- R9: `frame_strobe` is high for exactly one clock, during bit 0 of every frame except the first after a reset. In that clock the receive ports show the frame that has just completed.
- R10: The receive ports hold their values between frame strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock driven by the codec |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_reset | input | 1 | Synchronous request to reset the codec and restart the link |
| ac_rst_n | output | 1 | Active-low codec reset |
| ac_sync | output | 1 | Frame synchronisation to the codec |
| ac_sdata_out | output | 1 | Serial data to the codec |
| ac_sdata_in | input | 1 | Serial data from the codec |
| tx_tag | input | 16 | Outgoing slot 0 tag |
| tx_cmd_addr | input | 20 | Outgoing slot 1 command address |
| tx_cmd_data | input | 20 | Outgoing slot 2 command data |
| tx_pcm | input | 200 | Outgoing slots 3..12, slot 3 in the top 20 bits |
| rx_tag | output | 16 | Received slot 0 tag |
| rx_stat_addr | output | 20 | Received slot 1 status address |
| rx_stat_data | output | 20 | Received slot 2 status data |
| rx_pcm | output | 200 | Received slots 3..12, slot 3 in the top 20 bits |
| frame_strobe | output | 1 | One-clock pulse at each frame boundary |

## Verification
Every serial result is registered once, so a transmit bit or SYNC level decided at a rising edge is observed at the following falling edge.

Reset timing:
- The codec reset stays low for RST_CYCLES falling edges after release.
- The guard period then lasts GUARD_CYCLES falling edges.
- The falling edge after that is the SYNC lead-in.

Frame timing:
- Transmit inputs written at the falling edge of a lead-in or bit-255 clock appear on the line over the next 256 falling edges.
- A receive frame driven in bits 0 to 255 is published with the strobe seen at the 257th falling edge.

The bench tracks bit position from the SYNC rise on its own, pushes each expected frame into a queue when it is driven, and pops it exactly at those falling edges.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
    typedef enum logic [1:0] {
        LNK_RESET = 2'd0,
        LNK_GUARD = 2'd1,
        LNK_RUN   = 2'd2
    } lnk_state_e;
endpackage

// File: rtl/aclink_seq.sv
`timescale 1ns/1ps
module aclink_seq
    import aclink_pkg::*;
#(
    parameter int FRAME_LEN    = 256,
    parameter int SYNC_LEN     = 16,
    parameter int RST_CYCLES   = 16,
    parameter int GUARD_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         link_reset,
    output logic                         codec_rst_n,
    output logic                         sync,
    output logic                         drive_en,
    output logic                         frame_end,
    output logic [$clog2(FRAME_LEN)-1:0] nxt_idx,
    output logic                         frame_strobe
);
    localparam int CW   = $clog2(FRAME_LEN);
    localparam int TMAX = (RST_CYCLES > GUARD_CYCLES) ? RST_CYCLES : GUARD_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LAST      = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_LEN - 1);

    lnk_state_e      state_q, state_d;
    logic [TW-1:0]   tim_q;
    logic [CW-1:0]   cnt_q;
    logic            primed_q;
    logic            sync_q;
    logic            codec_rst_n_q;
    logic            strobe_q;

    assign drive_en     = (state_q == LNK_RUN) && !link_reset;
    assign frame_end    = drive_en && (cnt_q == LAST);
    assign nxt_idx      = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    assign sync         = sync_q;
    assign codec_rst_n  = codec_rst_n_q;
    assign frame_strobe = strobe_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_RESET: if (tim_q == TW'(RST_CYCLES - 1))   state_d = LNK_GUARD;
            LNK_GUARD: if (tim_q == TW'(GUARD_CYCLES - 1)) state_d = LNK_RUN;
            LNK_RUN:   state_d = LNK_RUN;
            default:   state_d = LNK_RESET;
        endcase
        if (link_reset) state_d = LNK_RESET;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_RESET;
        else        state_q <= state_d;
    end

    // outputs, timers and bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q         <= '0;
            cnt_q         <= '0;
            primed_q      <= 1'b0;
            sync_q        <= 1'b0;
            codec_rst_n_q <= 1'b0;
            strobe_q      <= 1'b0;
        end else begin
            codec_rst_n_q <= (state_d != LNK_RESET);
            strobe_q      <= frame_end && primed_q;
            if (link_reset || (state_d != state_q) || (state_q == LNK_RUN))
                tim_q <= '0;
            else
                tim_q <= tim_q + 1'b1;
            unique case (state_d)
                LNK_RUN: begin
                    primed_q <= primed_q || frame_end;
                    if (state_q == LNK_RUN) begin
                        cnt_q  <= nxt_idx;
                        sync_q <= (nxt_idx == LAST) || (nxt_idx < SYNC_LAST);
                    end else begin
                        cnt_q  <= LAST;
                        sync_q <= 1'b1;
                    end
                end
                default: begin
                    primed_q <= 1'b0;
                    cnt_q    <= '0;
                    sync_q   <= 1'b0;
                end
            endcase
        end
    end

    // R5: SYNC rises only in the last bit position (lead-in or bit 255)
    p_sync_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> (cnt_q == LAST));

    // R4: SYNC falls exactly when bit SYNC_LEN-1 goes out while running
    p_sync_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_q) && state_q == LNK_RUN) |-> (cnt_q == SYNC_LAST));

    // R9: the strobe is a single clock wide
    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);

    // R9: the strobe coincides with bit 0 of a running frame
    p_strobe_bit0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |-> (cnt_q == '0 && state_q == LNK_RUN));

    // R2: SYNC is quiet while the codec is held in reset
    p_sync_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_rst_n_q |-> !sync_q);
endmodule

// File: rtl/aclink_tx_frame.sv
`timescale 1ns/1ps
module aclink_tx_frame #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NPCM   = 10,
    parameter int FRAME_LEN = TAG_W + (NPCM + 2) * SLOT_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         drive_en,
    input  logic                         load,
    input  logic [$clog2(FRAME_LEN)-1:0] nxt_idx,
    input  logic [TAG_W-1:0]             tag,
    input  logic [SLOT_W-1:0]            cmd_addr,
    input  logic [SLOT_W-1:0]            cmd_data,
    input  logic [NPCM*SLOT_W-1:0]       pcm,
    output logic                         sdata_out
);
    localparam int CW = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] asm_frame;
    logic [FRAME_LEN-1:0] frame_q;
    logic [CW-1:0]        rd_idx;
    logic                 sdata_q;

    assign asm_frame[FRAME_LEN-1 -: TAG_W]              = tag;
    assign asm_frame[FRAME_LEN-TAG_W-1 -: SLOT_W]       = cmd_addr;
    assign asm_frame[FRAME_LEN-TAG_W-SLOT_W-1 -: SLOT_W] = cmd_data;

    // PCM slots in order, first slot in the most significant position
    for (genvar s = 0; s < NPCM; s++) begin : g_pcm_slot
        assign asm_frame[(NPCM-s)*SLOT_W-1 -: SLOT_W] = pcm[(NPCM-s)*SLOT_W-1 -: SLOT_W];
    end

    assign rd_idx    = LAST - nxt_idx;
    assign sdata_out = sdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            sdata_q <= 1'b0;
        end else begin
            if (load) frame_q <= asm_frame;
            if (!drive_en)  sdata_q <= 1'b0;
            else if (load)  sdata_q <= asm_frame[FRAME_LEN-1];
            else            sdata_q <= frame_q[rd_idx];
        end
    end

    // R7: the latched frame only changes at a frame boundary
    p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(frame_q));
endmodule

// File: rtl/aclink_rx_frame.sv
`timescale 1ns/1ps
module aclink_rx_frame #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int NPCM   = 10,
    parameter int FRAME_LEN = TAG_W + (NPCM + 2) * SLOT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic                   sdata_in,
    output logic [TAG_W-1:0]       tag,
    output logic [SLOT_W-1:0]      stat_addr,
    output logic [SLOT_W-1:0]      stat_data,
    output logic [NPCM*SLOT_W-1:0] pcm
);
    logic [FRAME_LEN-1:0] shift_q;
    logic [FRAME_LEN-1:0] held_q;

    // incoming bits are taken on the falling edge, mid-bit
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[FRAME_LEN-2:0], sdata_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held_q <= '0;
        else if (capture) held_q <= shift_q;
    end

    assign tag       = held_q[FRAME_LEN-1 -: TAG_W];
    assign stat_addr = held_q[FRAME_LEN-TAG_W-1 -: SLOT_W];
    assign stat_data = held_q[FRAME_LEN-TAG_W-SLOT_W-1 -: SLOT_W];
    assign pcm       = held_q[NPCM*SLOT_W-1:0];

    // R10: received slots are held between captures
    p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(held_q));
endmodule

// File: rtl/aclink_frame_engine.sv
`timescale 1ns/1ps
module aclink_frame_engine #(
    parameter int TAG_W        = 16,
    parameter int SLOT_W       = 20,
    parameter int NUM_SLOTS    = 13,
    parameter int RST_CYCLES   = 16,
    parameter int GUARD_CYCLES = 4
) (
    input  logic                         bit_clk,
    input  logic                         rst_n,
    input  logic                         link_reset,
    output logic                         ac_rst_n,
    output logic                         ac_sync,
    output logic                         ac_sdata_out,
    input  logic                         ac_sdata_in,
    input  logic [TAG_W-1:0]             tx_tag,
    input  logic [SLOT_W-1:0]            tx_cmd_addr,
    input  logic [SLOT_W-1:0]            tx_cmd_data,
    input  logic [(NUM_SLOTS-3)*SLOT_W-1:0] tx_pcm,
    output logic [TAG_W-1:0]             rx_tag,
    output logic [SLOT_W-1:0]            rx_stat_addr,
    output logic [SLOT_W-1:0]            rx_stat_data,
    output logic [(NUM_SLOTS-3)*SLOT_W-1:0] rx_pcm,
    output logic                         frame_strobe
);
    localparam int NPCM      = NUM_SLOTS - 3;
    localparam int FRAME_LEN = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
    localparam int CW        = $clog2(FRAME_LEN);

    logic          drive_en;
    logic          frame_end;
    logic [CW-1:0] nxt_idx;

    aclink_seq #(
        .FRAME_LEN   (FRAME_LEN),
        .SYNC_LEN    (TAG_W),
        .RST_CYCLES  (RST_CYCLES),
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_seq (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .link_reset  (link_reset),
        .codec_rst_n (ac_rst_n),
        .sync        (ac_sync),
        .drive_en    (drive_en),
        .frame_end   (frame_end),
        .nxt_idx     (nxt_idx),
        .frame_strobe(frame_strobe)
    );

    aclink_tx_frame #(
        .TAG_W    (TAG_W),
        .SLOT_W   (SLOT_W),
        .NPCM     (NPCM),
        .FRAME_LEN(FRAME_LEN)
    ) u_tx (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .drive_en (drive_en),
        .load     (frame_end),
        .nxt_idx  (nxt_idx),
        .tag      (tx_tag),
        .cmd_addr (tx_cmd_addr),
        .cmd_data (tx_cmd_data),
        .pcm      (tx_pcm),
        .sdata_out(ac_sdata_out)
    );

    aclink_rx_frame #(
        .TAG_W    (TAG_W),
        .SLOT_W   (SLOT_W),
        .NPCM     (NPCM),
        .FRAME_LEN(FRAME_LEN)
    ) u_rx (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .capture  (frame_end),
        .sdata_in (ac_sdata_in),
        .tag      (rx_tag),
        .stat_addr(rx_stat_addr),
        .stat_data(rx_stat_data),
        .pcm      (rx_pcm)
    );

    // R2: outgoing lines low while the codec reset is asserted
    p_reset_quiet_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !ac_rst_n |-> (!ac_sync && !ac_sdata_out));

    // R2: and still low in the cycle the codec reset is released
    p_release_quiet_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(ac_rst_n) |-> (!ac_sync && !ac_sdata_out));

    // R3: a link reset request asserts the codec reset at the next edge
    p_link_reset_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        link_reset |=> !ac_rst_n);
endmodule

// File: tb/aclink_frame_engine_tb.sv
`timescale 1ns/1ps
module aclink_frame_engine_tb;
    localparam int CLK_PERIOD   = 10;
    localparam int RST_CYCLES   = 16;
    localparam int GUARD_CYCLES = 4;
    localparam int FRAME        = 256;

    logic         bit_clk = 1'b0;
    logic         rst_n;
    logic         link_reset;
    logic         ac_rst_n, ac_sync, ac_sdata_out, ac_sdata_in;
    logic [15:0]  tx_tag;
    logic [19:0]  tx_cmd_addr, tx_cmd_data;
    logic [199:0] tx_pcm;
    logic [15:0]  rx_tag;
    logic [19:0]  rx_stat_addr, rx_stat_data;
    logic [199:0] rx_pcm;
    logic         frame_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    logic [255:0] tx_q[$];
    logic [255:0] rx_q[$];

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    aclink_frame_engine #(
        .RST_CYCLES  (RST_CYCLES),
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_dut (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .link_reset  (link_reset),
        .ac_rst_n    (ac_rst_n),
        .ac_sync     (ac_sync),
        .ac_sdata_out(ac_sdata_out),
        .ac_sdata_in (ac_sdata_in),
        .tx_tag      (tx_tag),
        .tx_cmd_addr (tx_cmd_addr),
        .tx_cmd_data (tx_cmd_data),
        .tx_pcm      (tx_pcm),
        .rx_tag      (rx_tag),
        .rx_stat_addr(rx_stat_addr),
        .rx_stat_data(rx_stat_data),
        .rx_pcm      (rx_pcm),
        .frame_strobe(frame_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rand_frame();
        logic [255:0] v;
        for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    // driver: new transmit slots, expected frame queued (R6, R7)
    task automatic drive_tx();
        logic [255:0] v = rand_frame();
        tx_tag      = v[255:240];
        tx_cmd_addr = v[239:220];
        tx_cmd_data = v[219:200];
        tx_pcm      = v[199:0];
        tx_q.push_back({tx_tag, tx_cmd_addr, tx_cmd_data, tx_pcm});
    endtask

    // counts reset and guard clocks; returns at the SYNC lead-in falling edge
    task automatic reset_sequence(input string req);
        int lo = 0;
        int gd = 0;
        bit quiet = 1'b1;
        forever begin
            @(negedge bit_clk);
            if (ac_sync || ac_sdata_out) quiet = 1'b0;
            if (ac_rst_n || lo > 1000) break;
            lo++;
        end
        while (ac_rst_n && !ac_sync && gd < 1000) begin
            if (ac_sdata_out) quiet = 1'b0;
            gd++;
            @(negedge bit_clk);
        end
        check(lo == RST_CYCLES, {req, " codec reset length"}, lo, RST_CYCLES);
        check(gd == GUARD_CYCLES, "R2 guard length", gd, GUARD_CYCLES);
        check(quiet, "R2 lines low during reset and guard", !quiet, 0);
        check(ac_sdata_out == 1'b0, "R5 lead-in data low", ac_sdata_out, 0);
    endtask

    // runs n frames starting at a SYNC-rise falling edge
    task automatic run_phase(input int n);
        fork
            begin : tx_driver
                for (int f = 0; f < n; f++) begin
                    drive_tx();
                    repeat (FRAME) @(negedge bit_clk);
                end
            end
            begin : tx_monitor
                for (int f = 0; f < n; f++) begin
                    logic [255:0] got = '0;
                    logic [255:0] exp;
                    int sync_bad = 0;
                    for (int k = 0; k < FRAME; k++) begin
                        @(negedge bit_clk);
                        got[255-k] = ac_sdata_out;
                        if (ac_sync != ((k < 15) || (k == 255))) sync_bad++;
                        if (k == 0)
                            check(ac_sync && ac_sdata_out == tx_q[0][255],
                                  "R5 tag MSB follows SYNC rise", ac_sdata_out, tx_q[0][255]);
                    end
                    exp = tx_q.pop_front();
                    check(sync_bad == 0, "R4 SYNC pattern", sync_bad, 0);
                    check(got == exp, "R6 R7 transmitted frame", got, exp);
                end
            end
            begin : rx_driver
                for (int f = 0; f < n; f++) begin
                    logic [255:0] v = rand_frame();
                    rx_q.push_back(v);
                    for (int k = 0; k < FRAME; k++) begin
                        @(posedge bit_clk);
                        #(CLK_PERIOD/4);
                        ac_sdata_in = v[255-k];
                    end
                end
            end
            begin : rx_monitor
                logic [255:0] last = '0;
                bit have_last = 1'b0;
                int unstable = 0;
                for (int i = 1; i <= FRAME*n + 1; i++) begin
                    logic [255:0] cur;
                    bit due;
                    @(negedge bit_clk);
                    cur = {rx_tag, rx_stat_addr, rx_stat_data, rx_pcm};
                    due = (i % FRAME == 1) && (i > 1);
                    if (due) begin
                        logic [255:0] exp = rx_q.pop_front();
                        check(frame_strobe, "R9 strobe at frame start", frame_strobe, 1);
                        check(cur == exp, "R8 received frame", cur, exp);
                        last = cur;
                        have_last = 1'b1;
                    end else begin
                        if (frame_strobe)
                            check(1'b0, "R9 unexpected strobe", i, 0);
                        if (have_last && cur != last) unstable++;
                    end
                end
                check(unstable == 0, "R10 receive ports held", unstable, 0);
            end
        join
    endtask

    initial begin : watchdog
        #(CLK_PERIOD*200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        rst_n       = 1'b0;
        link_reset  = 1'b0;
        ac_sdata_in = 1'b0;
        tx_tag      = '0;
        tx_cmd_addr = '0;
        tx_cmd_data = '0;
        tx_pcm      = '0;
        repeat (3) @(posedge bit_clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        check(!ac_rst_n && !ac_sync && !ac_sdata_out && !frame_strobe,
              "R1 outputs low in reset",
              {ac_rst_n, ac_sync, ac_sdata_out, frame_strobe}, 0);
        rst_n = 1'b1;
        reset_sequence("R1");
        run_phase(4);

        // R3: link reset mid-frame
        repeat (40) @(negedge bit_clk);
        link_reset = 1'b1;
        @(posedge bit_clk);
        #(CLK_PERIOD/4);
        link_reset = 1'b0;
        check(!ac_rst_n && !ac_sync && !ac_sdata_out, "R3 lines drop on link reset",
              {ac_rst_n, ac_sync, ac_sdata_out}, 0);
        reset_sequence("R3");
        run_phase(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule